// File: doc/BRIEF.md
# Sleep-Aware Watchdog Timer

This block is a watchdog that runs entirely on its own slow tick clock, apart from the processor clock. It therefore keeps counting while the core sleeps with its main clock stopped. A static configuration input is the only way to turn it off. Software cannot stop it; it can only restart the count with a clear request. When the count reaches its period, the block emits a one-tick time-out pulse. The same pulse also starts the device reset delay timer. Together with the pulse, the block raises one of two requests to the reset logic: a device reset if the core was awake, or a wake-up reset if the core was asleep.

The clear request and the sleep indication come from the core clock domain. Each passes through a two-stage synchronizer into the tick domain, and edge detection turns it into a one-tick event. A time-out status flag drops on every time-out and returns high on a clear or on entry into sleep. A second flag, the sleep-wake flag, records whether the most recent time-out happened while the core slept.

Control is a three-state machine:
- OFF holds the counter idle.
- AWAKE counts with the core running.
- ASLEEP counts with the core sleeping.

Transitions:
- ENABLE: OFF to AWAKE, when the configuration bit is 1.
- DOZE: AWAKE to ASLEEP, on a synchronized rising edge of the sleep input.
- ROUSE: ASLEEP to AWAKE, on a time-out or on a synchronized falling edge of the sleep input.
- KILL: any state to OFF, whenever the configuration bit is 0.

Top module: `wdog_sleepwake`

## Requirements
- R1: While `cfg_en` is 0 the block is held in OFF and the counter is held at zero. `tmo_pulse`, `rst_req` and `wake_req` stay 0, both in the tick where `cfg_en` is 0 and in the tick after it.
- R2: With the counter starting from zero, `tmo_pulse` goes high for exactly one tick after PERIOD ticks. The count then restarts from zero, so undisturbed pulses are PERIOD ticks apart. Out of reset with `cfg_en` at 1, the first pulse follows tick PERIOD+1.
- R3: A rising edge on `clr_req` is synchronized in two ticks and acts on the third tick edge after it is captured. It sets the counter to zero and sets `to_flag` to 1.
- R4: A rising edge on `sleep_req` acts with the same two-tick latency. It moves the block from AWAKE to ASLEEP, sets the counter to zero and sets `to_flag` to 1.
- R5: A time-out in AWAKE raises `rst_req` for the same single tick as `tmo_pulse`, and leaves `wake_req` at 0.
- R6: A time-out in ASLEEP raises `wake_req` for the same single tick as `tmo_pulse`, leaves `rst_req` at 0, and returns the block to AWAKE. A synchronized falling edge of `sleep_req` also returns it to AWAKE.
- R7: `to_flag` resets to 1 and drops to 0 in the tick of every `tmo_pulse`.
- R8: `slp_flag` resets to 0. On each time-out it takes the value 1 if the time-out came from ASLEEP and 0 if it came from AWAKE.
- R9: If a clear or a sleep entry acts on the same tick edge as the terminal count, the restart wins. No time-out occurs, and the next one follows PERIOD ticks later.
- R10: During reset the block is in OFF, the counter is zero, `tmo_pulse`, `rst_req`, `wake_req` and `slp_flag` are 0, and `to_flag` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tick | input | 1 | Free-running watchdog tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Static configuration enable; 0 disables the watchdog |
| clr_req | input | 1 | Clear request from the core clock domain |
| sleep_req | input | 1 | Level that is high while the core sleeps |
| tmo_pulse | output | 1 | One-tick time-out pulse, also the reset delay timer trigger |
| rst_req | output | 1 | Device reset request, time-out while awake |
| wake_req | output | 1 | Wake-up reset request, time-out while asleep |
| to_flag | output | 1 | Time-out status, 0 after a time-out |
| slp_flag | output | 1 | 1 when the last time-out occurred during sleep |

## Verification
Two events can collide with the terminal count. A synchronized clear can act on the very tick edge where the counter would expire, and so can a synchronized sleep entry. The bench sweeps the drive offset of each event across a full period and beyond, so every alignment is hit, including the exact collision. A cycle-level reference model in the bench predicts every output at each tick. A separate check counts pulses across the collision window and expects none before tick 2*PERIOD+1.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WS_OFF    = 2'd0,
        WS_AWAKE  = 2'd1,
        WS_ASLEEP = 2'd2
    } wdt_state_e;

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int LANES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] async_in,
    output logic [LANES-1:0] rise,
    output logic [LANES-1:0] fall
);

    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [STAGES-1:0] chain;
        logic              prev;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
                prev  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], async_in[g]};
                prev  <= chain[LAST];
            end
        end

        assign rise[g] = chain[LAST] & ~prev;
        assign fall[g] = ~chain[LAST] & prev;
    end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int PERIOD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic terminal
);

    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LIMIT = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    assign terminal = run && (cnt == LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || restart || terminal) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdt_fsm.sv
module wdt_fsm
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_en,
    input  logic clr_rise,
    input  logic slp_rise,
    input  logic slp_fall,
    input  logic terminal,
    output logic run,
    output logic restart,
    output logic tmo_pulse,
    output logic rst_req,
    output logic wake_req,
    output logic to_flag,
    output logic slp_flag
);

    wdt_state_e state, state_nx;
    logic       expire;

    assign run     = cfg_en && (state != WS_OFF);
    assign restart = clr_rise || slp_rise;
    assign expire  = terminal && !restart;

    always_comb begin
        state_nx = state;
        if (!cfg_en) begin
            state_nx = WS_OFF;
        end else begin
            unique case (state)
                WS_OFF:    state_nx = WS_AWAKE;
                WS_AWAKE:  if (slp_rise) state_nx = WS_ASLEEP;
                WS_ASLEEP: if (expire || slp_fall) state_nx = WS_AWAKE;
                default:   state_nx = WS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WS_OFF;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_pulse <= 1'b0;
            rst_req   <= 1'b0;
            wake_req  <= 1'b0;
            to_flag   <= 1'b1;
            slp_flag  <= 1'b0;
        end else begin
            tmo_pulse <= expire;
            rst_req   <= expire && (state == WS_AWAKE);
            wake_req  <= expire && (state == WS_ASLEEP);
            if (expire) begin
                to_flag  <= 1'b0;
                slp_flag <= (state == WS_ASLEEP);
            end else if (restart) begin
                to_flag  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/wdog_sleepwake.sv
module wdog_sleepwake #(
    parameter int PERIOD = 16
) (
    input  logic clk_tick,
    input  logic rst_n,
    input  logic cfg_en,
    input  logic clr_req,
    input  logic sleep_req,
    output logic tmo_pulse,
    output logic rst_req,
    output logic wake_req,
    output logic to_flag,
    output logic slp_flag
);

    logic [1:0] ev_rise, ev_fall;
    logic       run, restart, terminal;

    wdt_sync #(.LANES(2), .STAGES(2)) u_sync (
        .clk      (clk_tick),
        .rst_n    (rst_n),
        .async_in ({sleep_req, clr_req}),
        .rise     (ev_rise),
        .fall     (ev_fall)
    );

    wdt_counter #(.PERIOD(PERIOD)) u_cnt (
        .clk      (clk_tick),
        .rst_n    (rst_n),
        .run      (run),
        .restart  (restart),
        .terminal (terminal)
    );

    wdt_fsm u_fsm (
        .clk       (clk_tick),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .clr_rise  (ev_rise[0]),
        .slp_rise  (ev_rise[1]),
        .slp_fall  (ev_fall[1]),
        .terminal  (terminal),
        .run       (run),
        .restart   (restart),
        .tmo_pulse (tmo_pulse),
        .rst_req   (rst_req),
        .wake_req  (wake_req),
        .to_flag   (to_flag),
        .slp_flag  (slp_flag)
    );

endmodule

// File: rtl/wdt_checks.sv
module wdt_checks (
    input logic clk_tick,
    input logic rst_n,
    input logic cfg_en,
    input logic tmo_pulse,
    input logic rst_req,
    input logic wake_req,
    input logic to_flag,
    input logic slp_flag
);

    AST_PULSE_ONE_TICK: assert property (@(posedge clk_tick) disable iff (!rst_n)
        tmo_pulse |=> !tmo_pulse);                                  // R2
    AST_OFF_NO_TMO: assert property (@(posedge clk_tick) disable iff (!rst_n)
        !cfg_en |=> !tmo_pulse);                                    // R1
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk_tick) disable iff (!rst_n)
        $onehot0({rst_req, wake_req}));                             // R5
    AST_REQ_NEEDS_TMO: assert property (@(posedge clk_tick) disable iff (!rst_n)
        (rst_req || wake_req) |-> tmo_pulse);                       // R6
    AST_TMO_HAS_REQ: assert property (@(posedge clk_tick) disable iff (!rst_n)
        tmo_pulse |-> (rst_req || wake_req));                       // R5
    AST_TMO_DROPS_FLAG: assert property (@(posedge clk_tick) disable iff (!rst_n)
        tmo_pulse |-> !to_flag);                                    // R7
    AST_WAKE_MARKS: assert property (@(posedge clk_tick) disable iff (!rst_n)
        wake_req |-> slp_flag);                                     // R8
    AST_RESET_UNMARKS: assert property (@(posedge clk_tick) disable iff (!rst_n)
        rst_req |-> !slp_flag);                                     // R8

endmodule

bind wdog_sleepwake wdt_checks u_chk (
    .clk_tick  (clk_tick),
    .rst_n     (rst_n),
    .cfg_en    (cfg_en),
    .tmo_pulse (tmo_pulse),
    .rst_req   (rst_req),
    .wake_req  (wake_req),
    .to_flag   (to_flag),
    .slp_flag  (slp_flag)
);

// File: tb/wdog_sleepwake_test.sv
`timescale 1ns/1ps
module wdog_sleepwake_test;

    localparam int P = 8;

    logic clk_tick = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0;
    logic clr_req = 1'b0;
    logic sleep_req = 1'b0;
    logic tmo_pulse, rst_req, wake_req, to_flag, slp_flag;

    int tests = 0;
    int fails = 0;
    int npulse = 0;
    int nwake = 0;
    bit done = 1'b0;

    always #10 clk_tick = ~clk_tick;

    wdog_sleepwake #(.PERIOD(P)) uut (
        .clk_tick  (clk_tick),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .clr_req   (clr_req),
        .sleep_req (sleep_req),
        .tmo_pulse (tmo_pulse),
        .rst_req   (rst_req),
        .wake_req  (wake_req),
        .to_flag   (to_flag),
        .slp_flag  (slp_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model built from the requirements: 0=OFF 1=AWAKE 2=ASLEEP
    logic c1, c2, c3, z1, z2, z3;
    int   ms, mc;
    logic e_tmo, e_rst, e_wake, e_to, e_slp;
    logic crise, srise, sfall, mexp;

    always @(posedge clk_tick or negedge rst_n) begin
        if (!rst_n) begin
            {c1, c2, c3, z1, z2, z3} <= '0;
            ms <= 0; mc <= 0;
            e_tmo <= 0; e_rst <= 0; e_wake <= 0; e_to <= 1; e_slp <= 0;
        end else begin
            crise = c2 & ~c3;
            srise = z2 & ~z3;
            sfall = ~z2 & z3;
            mexp  = cfg_en && (ms != 0) && (mc == P-1) && !crise && !srise;
            c1 <= clr_req;   c2 <= c1; c3 <= c2;
            z1 <= sleep_req; z2 <= z1; z3 <= z2;
            mc <= (!cfg_en || ms == 0 || crise || srise || mexp) ? 0 : mc + 1;
            if (!cfg_en)      ms <= 0;
            else if (ms == 0) ms <= 1;
            else if (ms == 1) ms <= srise ? 2 : 1;
            else              ms <= (mexp || sfall) ? 1 : 2;
            e_tmo  <= mexp;
            e_rst  <= mexp && ms == 1;
            e_wake <= mexp && ms == 2;
            if (mexp) begin
                e_to  <= 0;
                e_slp <= (ms == 2);
            end else if (crise || srise) begin
                e_to <= 1;
            end
        end
    end

    // Per-tick comparison, 5 ns after the active edge
    always @(posedge clk_tick) begin
        #5;
        if (rst_n && !done) begin
            if (tmo_pulse) npulse++;
            if (wake_req) nwake++;
            check(tmo_pulse == e_tmo, "R2 tmo_pulse", tmo_pulse, e_tmo);
            check(rst_req == e_rst, "R5 rst_req", rst_req, e_rst);
            check(wake_req == e_wake, "R6 wake_req", wake_req, e_wake);
            check(to_flag == e_to, "R7 to_flag", to_flag, e_to);
            check(slp_flag == e_slp, "R8 slp_flag", slp_flag, e_slp);
        end
    end

    task automatic do_reset();
        @(negedge clk_tick);
        rst_n = 1'b0;
        clr_req = 1'b0;
        sleep_req = 1'b0;
        @(negedge clk_tick);
        check(tmo_pulse == 0 && rst_req == 0 && wake_req == 0, "R10 outputs idle", tmo_pulse, 0);
        check(to_flag == 1, "R10 to_flag", to_flag, 1);
        check(slp_flag == 0, "R10 slp_flag", slp_flag, 0);
        @(negedge clk_tick);
        rst_n = 1'b1;
        npulse = 0;
        nwake = 0;
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk_tick);
    endtask

    initial begin
        repeat (100000) @(posedge clk_tick);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: disabled watchdog never expires
        cfg_en = 1'b0;
        do_reset();
        ticks(3*P);
        check(npulse == 0, "R1 disabled pulses", npulse, 0);

        // R2: free-running period
        cfg_en = 1'b1;
        do_reset();
        ticks(P);
        check(npulse == 0, "R2 no pulse by tick P", npulse, 0);
        ticks(1);
        check(npulse == 1, "R2 first pulse at tick P+1", npulse, 1);
        ticks(2*P);
        check(npulse == 3, "R2 pulses every P ticks", npulse, 3);

        // R9: clear collides with terminal count (acts on edge P+1)
        do_reset();
        ticks(P-2);
        clr_req = 1'b1;
        ticks(1);
        clr_req = 1'b0;
        ticks(P+1);
        check(npulse == 0, "R9 clear beats terminal", npulse, 0);
        ticks(1);
        check(npulse == 1, "R3 pulse P ticks after clear", npulse, 1);

        // R9: sleep entry collides with terminal count
        do_reset();
        ticks(P-2);
        sleep_req = 1'b1;
        ticks(P+2);
        check(npulse == 0, "R9 sleep beats terminal", npulse, 0);
        ticks(1);
        check(nwake == 1, "R6 wake after sleep period", nwake, 1);
        check(slp_flag == 1, "R8 flag marks sleep", slp_flag, 1);
        sleep_req = 1'b0;
        ticks(P+2);
        check(slp_flag == 0, "R8 flag cleared by awake time-out", slp_flag, 0);

        // R3 / R9: clear at every offset across a period
        for (int k = 0; k <= P+2; k++) begin
            do_reset();
            ticks(k);
            clr_req = 1'b1;
            ticks(1);
            clr_req = 1'b0;
            ticks(2*P+3);
        end

        // R4 / R6 / R8: sleep entry at every offset
        for (int k = 0; k <= P+2; k++) begin
            do_reset();
            ticks(k);
            sleep_req = 1'b1;
            ticks(2*P+4);
            sleep_req = 1'b0;
            ticks(P+3);
        end

        // R6: early wake by sleep release, then R1 disable mid-count
        do_reset();
        ticks(2);
        sleep_req = 1'b1;
        ticks(4);
        sleep_req = 1'b0;
        ticks(P+4);
        cfg_en = 1'b0;
        npulse = 0;
        ticks(3*P);
        check(npulse == 0, "R1 disable mid-count", npulse, 0);
        cfg_en = 1'b1;
        ticks(2*P);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule